// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a single-cycle 32-bit processor and works out, every clock, which address the next instruction is fetched from. The current instruction's decoded control strobes (branch-if-equal, branch-if-not-equal, jump), its 16-bit offset field, its 26-bit target field and the ALU zero flag from the register comparison come in. The registered PC goes out and addresses the instruction memory directly. Fetch is sequential unless a taken branch or a jump redirects it.

Instructions are word sized and word aligned, so only the upper 30 bits of the PC are stored and counted. The two low bits of the output are tied to zero. The PC updates once per clock, on the same edge that writes the destination register of the instruction being completed.

Top module: `pc_next_unit`

## Requirements
- R1: With `rst` high at a rising clock edge, the PC becomes 0x00000000 after that edge, whatever the strobes carry.
- R2: `pc_o[1:0]` is always 2'b00.
- R3: With no strobe asserted, the next PC is PC+4.
- R4: With `br_eq_i` high and `alu_zero_i` high, the next PC is PC+4 plus the sign-extended 16-bit `imm16_i` shifted left by two. With `br_eq_i` high and `alu_zero_i` low (and no other strobe), the next PC is PC+4.
- R5: With `br_ne_i` high and `alu_zero_i` low, the next PC is the branch target defined in R4. With `br_ne_i` high and `alu_zero_i` high (and no other strobe), the next PC is PC+4. If both branch strobes are high, the branch is taken when either condition holds.
- R6: With `jump_i` high, the next PC is bits [31:28] of PC+4, then `jidx_i[25:0]`, then 2'b00. The region bits therefore come from PC+4 even when PC+4 has crossed into the next 256 MB region.
- R7: `jump_i` has priority: when it is high, the branch strobes and the zero flag have no effect.
- R8: All address arithmetic wraps modulo 2^32. 0xFFFFFFFC+4 gives 0, and a negative offset below zero wraps to the top of memory. No error is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imm16_i | input | 16 | Signed word offset field of the branch instruction |
| jidx_i | input | 26 | Word index field of the jump instruction |
| br_eq_i | input | 1 | Current instruction is branch-if-equal |
| br_ne_i | input | 1 | Current instruction is branch-if-not-equal |
| jump_i | input | 1 | Current instruction is an absolute jump |
| alu_zero_i | input | 1 | ALU zero flag: the compared registers are equal |
| pc_o | output | 32 | Current program counter, instruction memory address |

## Verification
The bench targets the following corner cases:
- Zero-flag polarity for both branch kinds. A swapped condition takes a branch where it should fall through, and the PC lands 64 bytes off.
- The most negative offset (0x8000) taken from a low address. A design that zero-extends the offset jumps forward instead of wrapping to 0xFFFE0104.
- A jump issued from 0x0FFFFFFC, where PC+4 has entered the next region. A design that takes the region bits from the PC itself stays in region 0 and lands at 0x00000008 rather than 0x10000008.
- Both branch strobes at once, a jump together with a taken branch, 0xFFFFFFFC rolling over to zero, and a reset asserted while a jump is pending. Each of these shows up as a wrong address one edge later.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

   // Source of the next fetch address
   typedef enum logic [1:0] {
      SRC_SEQ    = 2'd0,
      SRC_BRANCH = 2'd1,
      SRC_JUMP   = 2'd2
   } next_src_e;

endpackage

// File: rtl/pcn_word_incr.sv
module pcn_word_incr #(
   parameter int unsigned WORD_W = 30,
   parameter bit          SPLIT  = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned LO_W = WORD_W / 2;
   localparam int unsigned HI_W = WORD_W - LO_W;

   generate
      if (SPLIT && WORD_W >= 8) begin : g_split
         // Two short halves: the low-half carry selects the upper half
         logic [LO_W:0]   lo_sum;
         logic [HI_W-1:0] hi_inc;
         assign lo_sum = {1'b0, word_i[LO_W-1:0]} + {{LO_W{1'b0}}, 1'b1};
         assign hi_inc = word_i[WORD_W-1:LO_W] + {{(HI_W-1){1'b0}}, 1'b1};
         assign word_o = {(lo_sum[LO_W] ? hi_inc : word_i[WORD_W-1:LO_W]),
                          lo_sum[LO_W-1:0]};
      end else begin : g_flat
         assign word_o = word_i + {{(WORD_W-1){1'b0}}, 1'b1};
      end
   endgenerate

endmodule

// File: rtl/pcn_branch_adder.sv
module pcn_branch_adder #(
   parameter int unsigned WORD_W = 30,
   parameter int unsigned IMM_W  = 16
) (
   input  logic [WORD_W-1:0] seq_word_i,
   input  logic [IMM_W-1:0]  offset_i,
   output logic [WORD_W-1:0] target_o
);
   logic [WORD_W-1:0] offset_ext;

   generate
      if (IMM_W >= WORD_W) begin : g_trunc
         assign offset_ext = offset_i[WORD_W-1:0];
      end else begin : g_sext
         assign offset_ext = {{(WORD_W-IMM_W){offset_i[IMM_W-1]}}, offset_i};
      end
   endgenerate

   // Word-granular add: the byte-level x4 is implicit
   assign target_o = seq_word_i + offset_ext;

endmodule

// File: rtl/pcn_jump_former.sv
module pcn_jump_former #(
   parameter int unsigned WORD_W = 30,
   parameter int unsigned JIDX_W = 26
) (
   input  logic [WORD_W-1:0] seq_word_i,
   input  logic [JIDX_W-1:0] jidx_i,
   output logic [WORD_W-1:0] target_o
);
   localparam int unsigned REGION_W = (WORD_W > JIDX_W) ? WORD_W - JIDX_W : 0;

   generate
      if (REGION_W == 0) begin : g_full
         assign target_o = jidx_i[WORD_W-1:0];
      end else begin : g_region
         assign target_o = {seq_word_i[WORD_W-1 -: REGION_W], jidx_i};
      end
   endgenerate

endmodule

// File: rtl/pcn_src_select.sv
module pcn_src_select
   import pcn_pkg::*;
#(
   parameter int unsigned WORD_W = 30
) (
   input  logic              br_eq_i,
   input  logic              br_ne_i,
   input  logic              jump_i,
   input  logic              zero_i,
   input  logic [WORD_W-1:0] seq_word_i,
   input  logic [WORD_W-1:0] br_word_i,
   input  logic [WORD_W-1:0] jmp_word_i,
   output logic [WORD_W-1:0] next_word_o
);
   next_src_e src;
   logic      taken;

   assign taken = (br_eq_i & zero_i) | (br_ne_i & ~zero_i);

   always_comb begin
      if (jump_i)     src = SRC_JUMP;
      else if (taken) src = SRC_BRANCH;
      else            src = SRC_SEQ;
   end

   always_comb begin
      unique case (src)
         SRC_JUMP:   next_word_o = jmp_word_i;
         SRC_BRANCH: next_word_o = br_word_i;
         default:    next_word_o = seq_word_i;
      endcase
   end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WORD_LSB   = 2,
   parameter int unsigned IMM_W      = 16,
   parameter int unsigned JIDX_W     = 26,
   parameter bit          SPLIT_INC  = 1'b1,
   parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IMM_W-1:0]  imm16_i,
   input  logic [JIDX_W-1:0] jidx_i,
   input  logic              br_eq_i,
   input  logic              br_ne_i,
   input  logic              jump_i,
   input  logic              alu_zero_i,
   output logic [ADDR_W-1:0] pc_o
);
   localparam int unsigned WORD_W = ADDR_W - WORD_LSB;
   localparam logic [WORD_W-1:0] RESET_WORD = RESET_ADDR[ADDR_W-1:WORD_LSB];

   initial begin
      if (WORD_LSB < 1)          $error("pc_next_unit: WORD_LSB must be at least 1");
      if (ADDR_W > 32)           $error("pc_next_unit: ADDR_W above 32 unsupported");
      if (JIDX_W >= WORD_W)      $error("pc_next_unit: JIDX_W leaves no region bits");
      if (IMM_W >= WORD_W)       $error("pc_next_unit: IMM_W must be below word width");
      if (RESET_ADDR[WORD_LSB-1:0] != '0) $error("pc_next_unit: RESET_ADDR not aligned");
   end

   logic [WORD_W-1:0] pc_word_q;
   logic [WORD_W-1:0] seq_word;
   logic [WORD_W-1:0] br_word;
   logic [WORD_W-1:0] jmp_word;
   logic [WORD_W-1:0] next_word;

   pcn_word_incr #(.WORD_W(WORD_W), .SPLIT(SPLIT_INC)) u_incr (
      .word_i (pc_word_q),
      .word_o (seq_word)
   );

   pcn_branch_adder #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_br (
      .seq_word_i (seq_word),
      .offset_i   (imm16_i),
      .target_o   (br_word)
   );

   pcn_jump_former #(.WORD_W(WORD_W), .JIDX_W(JIDX_W)) u_jmp (
      .seq_word_i (seq_word),
      .jidx_i     (jidx_i),
      .target_o   (jmp_word)
   );

   pcn_src_select #(.WORD_W(WORD_W)) u_sel (
      .br_eq_i     (br_eq_i),
      .br_ne_i     (br_ne_i),
      .jump_i      (jump_i),
      .zero_i      (alu_zero_i),
      .seq_word_i  (seq_word),
      .br_word_i   (br_word),
      .jmp_word_i  (jmp_word),
      .next_word_o (next_word)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_word_q <= RESET_WORD;
      else     pc_word_q <= next_word;
   end

   assign pc_o = {pc_word_q, {WORD_LSB{1'b0}}};

endmodule

// File: rtl/pcn_checks.sv
module pcn_checks #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned IMM_W      = 16,
   parameter int unsigned JIDX_W     = 26,
   parameter logic [31:0] RESET_ADDR = 32'h0000_0000
) (
   input logic              clk,
   input logic              rst,
   input logic [IMM_W-1:0]  imm16_i,
   input logic [JIDX_W-1:0] jidx_i,
   input logic              br_eq_i,
   input logic              br_ne_i,
   input logic              jump_i,
   input logic              alu_zero_i,
   input logic [ADDR_W-1:0] pc_o
);
   localparam int unsigned REGION_W = ADDR_W - JIDX_W - 2;

   logic [ADDR_W-1:0] exp_seq, exp_br, exp_jmp;
   assign exp_seq = pc_o + ADDR_W'(4);
   assign exp_br  = exp_seq + {{(ADDR_W-IMM_W-2){imm16_i[IMM_W-1]}}, imm16_i, 2'b00};
   assign exp_jmp = {exp_seq[ADDR_W-1 -: REGION_W], jidx_i, 2'b00};

   // R1: synchronous reset value
   p_reset_r1: assert property (@(posedge clk) rst |=> pc_o == RESET_ADDR[ADDR_W-1:0]);

   // R2: word alignment
   p_aligned_r2: assert property (@(posedge clk) disable iff (rst) pc_o[1:0] == 2'b00);

   // R3: sequential flow
   p_seq_r3: assert property (@(posedge clk) disable iff (rst)
      (!jump_i && !br_eq_i && !br_ne_i) |=> pc_o == $past(exp_seq));

   // R4: beq taken / not taken
   p_beq_taken_r4: assert property (@(posedge clk) disable iff (rst)
      (!jump_i && br_eq_i && alu_zero_i) |=> pc_o == $past(exp_br));
   p_beq_fall_r4: assert property (@(posedge clk) disable iff (rst)
      (!jump_i && br_eq_i && !br_ne_i && !alu_zero_i) |=> pc_o == $past(exp_seq));

   // R5: bne taken / not taken
   p_bne_taken_r5: assert property (@(posedge clk) disable iff (rst)
      (!jump_i && br_ne_i && !alu_zero_i) |=> pc_o == $past(exp_br));
   p_bne_fall_r5: assert property (@(posedge clk) disable iff (rst)
      (!jump_i && br_ne_i && !br_eq_i && alu_zero_i) |=> pc_o == $past(exp_seq));

   // R6, R7: jump target and its priority over branches
   p_jump_r6_r7: assert property (@(posedge clk) disable iff (rst)
      jump_i |=> pc_o == $past(exp_jmp));

endmodule

bind pc_next_unit pcn_checks #(
   .ADDR_W     (ADDR_W),
   .IMM_W      (IMM_W),
   .JIDX_W     (JIDX_W),
   .RESET_ADDR (RESET_ADDR)
) u_pcn_checks (
   .clk        (clk),
   .rst        (rst),
   .imm16_i    (imm16_i),
   .jidx_i     (jidx_i),
   .br_eq_i    (br_eq_i),
   .br_ne_i    (br_ne_i),
   .jump_i     (jump_i),
   .alu_zero_i (alu_zero_i),
   .pc_o       (pc_o)
);

// File: tb/pc_next_unit_test.sv
`timescale 1ns/1ps
module pc_next_unit_test;
   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] imm16;
   logic [25:0] jidx;
   logic        br_eq, br_ne, jump, zero;
   logic [31:0] pc;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pc_next_unit uut (
      .clk(clk), .rst(rst), .imm16_i(imm16), .jidx_i(jidx),
      .br_eq_i(br_eq), .br_ne_i(br_ne), .jump_i(jump),
      .alu_zero_i(zero), .pc_o(pc)
   );

   // {br_eq, br_ne, jump, zero, imm16, jidx, expected PC after the edge}
   localparam int NV = 12;
   localparam logic [77:0] VEC [NV] = '{
      {4'b0000, 16'h0000, 26'h0000000, 32'h0000_0004},  // R3 sequential
      {4'b0000, 16'h0000, 26'h0000000, 32'h0000_0008},  // R3 sequential
      {4'b1001, 16'h0010, 26'h0000000, 32'h0000_004C},  // R4 beq taken
      {4'b1000, 16'h0010, 26'h0000000, 32'h0000_0050},  // R4 beq falls through
      {4'b0100, 16'hFFFE, 26'h0000000, 32'h0000_004C},  // R5 bne taken, backward
      {4'b0101, 16'h0005, 26'h0000000, 32'h0000_0050},  // R5 bne falls through
      {4'b0010, 16'h0000, 26'h0000100, 32'h0000_0400},  // R6 jump
      {4'b1011, 16'h7FFF, 26'h0000040, 32'h0000_0100},  // R7 jump beats taken beq
      {4'b1001, 16'h8000, 26'h0000000, 32'hFFFE_0104},  // R8 negative wrap
      {4'b0010, 16'h0000, 26'h3FFFFFF, 32'hFFFF_FFFC},  // R6 jump in top region
      {4'b0000, 16'h0000, 26'h0000000, 32'h0000_0000},  // R8 sequential rollover
      {4'b1100, 16'h0003, 26'h0000000, 32'h0000_0010}   // R5 both strobes, bne wins
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: pc actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [77:0] v);
      {br_eq, br_ne, jump, zero} = v[77:74];
      imm16 = v[73:58];
      jidx  = v[57:32];
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      rst = 1'b1;
      drive('0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 reset value", pc, 32'h0);
      rst = 1'b0;
      drive(VEC[0]);
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         check($sformatf("vector %0d (R3..R8)", i), pc, VEC[i][31:0]);
         check("R2 low bits zero", {30'h0, pc[1:0]}, 32'h0);
         if (i + 1 < NV) drive(VEC[i+1]);
         else            drive('0);
      end

      // R6: region bits come from PC+4 crossing into the next region
      drive({4'b0010, 16'h0, 26'h3FFFFFF, 32'h0});
      @(negedge clk);
      check("R6 reach region edge", pc, 32'h0FFF_FFFC);
      drive({4'b0010, 16'h0, 26'h0000002, 32'h0});
      @(negedge clk);
      check("R6 region from PC+4", pc, 32'h1000_0008);

      // R1: reset overrides a pending jump and a taken branch
      rst = 1'b1;
      drive({4'b0010, 16'h0, 26'h0000005, 32'h0});
      @(negedge clk);
      check("R1 reset beats jump", pc, 32'h0);
      drive({4'b1001, 16'h0040, 26'h0, 32'h0});
      @(negedge clk);
      check("R1 reset beats branch", pc, 32'h0);
      rst = 1'b0;
      drive('0);
      @(negedge clk);
      check("R3 resume after reset", pc, 32'h4);
      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
         finish_run();
      end
   end

endmodule